// File: doc/BRIEF.md
# One-Period Ring Gate Generator

This block sits between a squaring front end and a period counter in a ringing detector. It watches a squared ringing waveform and opens a single enable window that lasts exactly one period of that waveform, measured from one falling edge to the next. A downstream counter counts system clocks while the window is open and so obtains the period of the ring signal.

The input is brought into the system clock domain by a short synchroniser chain and edges are found synchronously. Two cascaded toggle stages form the window. The opening stage toggles on falling ring edges. The locking stage toggles when the opening stage closes. Once the locking stage has fired, its feedback blocks the ring edges from the opening stage, so the window stays closed. A one-clock done pulse marks the close. An arm strobe clears both stages and starts a fresh measurement.

Top module: `ring_gate`

## Requirements
- R1: After reset, `win` and `done` are 0, and both toggle stages are clear, so a measurement can start without an arm strobe.
- R2: With the default two-stage synchroniser, a 1-to-0 change on `ring_in` made just after clock edge k opens the window: `win` is 1 after edge k+3 and still 0 after edge k+2.
- R3: A 0-to-1 change on `ring_in` (logic high means the squared signal is at supply, low means near ground) never opens or closes the window.
- R4: The window closes on the next 1-to-0 change of `ring_in`, with the same latency as R2, so `win` is high for exactly as many clocks as there are between the two falling edges.
- R5: `done` is 1 for exactly one clock, starting one clock after `win` goes low at the end of a full period.
- R6: After the window has closed, further falling or rising edges on `ring_in` have no effect: `win` and `done` stay 0 until the next arm strobe.
- R7: An `arm` pulse clears both stages; the next falling edge of `ring_in` then opens a new window.
- R8: An `arm` pulse while the window is open closes it after the next clock edge, and no `done` pulse follows.
- R9: If no second falling edge arrives, `win` stays 1 indefinitely and `done` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Synchronous clear and re-arm strobe for both stages |
| ring_in | input | 1 | Squared ringing signal, asynchronous to clk |
| win | output | 1 | Enable window, high for one ring period |
| done | output | 1 | One-clock pulse when the window closes |

## Verification
The hardest case to reach from the ports is a falling edge arriving after the lock has engaged. Only the feedback keeps the window shut then, and the window pin is already low, so a missing block would only show as the window reopening. Each table vector therefore drives a third falling edge after the period has closed, counts every window-high cycle and done pulse across the whole sequence, and so catches a window that reopens. Separate directed tests arm the block in the middle of an open window, to show that no done pulse leaks out, and hold the input low for a long time to show that the window never times out.

// File: rtl/ring_gate_pkg.sv
package ring_gate_pkg;
  // Falling transition between two consecutive samples.
  function automatic logic fell(input logic prev, input logic cur);
    return prev & ~cur;
  endfunction

  // Rising transition between two consecutive samples.
  function automatic logic rose(input logic prev, input logic cur);
    return ~prev & cur;
  endfunction

  // Next state of a toggle stage with synchronous clear priority.
  function automatic logic tgl_next(input logic q, input logic clr, input logic tgl);
    if (clr) return 1'b0;
    return tgl ? ~q : q;
  endfunction
endpackage

// File: rtl/rg_sync.sv
module rg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rg_edge.sv
module rg_edge
  import ring_gate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic sig,
  output logic rise_evt,
  output logic fall_evt
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   prev <= 1'b0;
    else if (clr) prev <= 1'b0;
    else          prev <= sig;
  end

  assign rise_evt = rose(prev, sig);
  assign fall_evt = fell(prev, sig);
endmodule

// File: rtl/rg_toggle.sv
module rg_toggle
  import ring_gate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tgl,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= tgl_next(q, clr, tgl);
  end

  AST_TGL_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (tgl && !clr) |=> (q != $past(q)));  // R4
  AST_TGL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !q);  // R7
endmodule

// File: rtl/ring_gate.sv
module ring_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic ring_in,
  output logic win,
  output logic done
);
  logic ring_s;
  logic ring_rise, ring_fall;
  logic open_q, lock_q;
  logic open_tgl, lock_tgl;
  logic open_rise_unused, open_fall;
  logic gate_pass;
  logic done_q;

  rg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ring_in), .q(ring_s)
  );

  rg_edge u_ring_edge (
    .clk(clk), .rst_n(rst_n), .clr(1'b0), .sig(ring_s),
    .rise_evt(ring_rise), .fall_evt(ring_fall)
  );

  // Feedback: the locking stage blocks edges from the opening stage.
  assign gate_pass = ~lock_q;
  assign open_tgl  = ring_fall & gate_pass;

  rg_toggle u_open (
    .clk(clk), .rst_n(rst_n), .clr(arm), .tgl(open_tgl), .q(open_q)
  );

  // Locking stage fires on a rise of the opening stage's complement.
  rg_edge u_open_edge (
    .clk(clk), .rst_n(rst_n), .clr(arm), .sig(open_q),
    .rise_evt(open_rise_unused), .fall_evt(open_fall)
  );

  assign lock_tgl = open_fall & ~lock_q;

  rg_toggle u_lock (
    .clk(clk), .rst_n(rst_n), .clr(arm), .tgl(lock_tgl), .q(lock_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   done_q <= 1'b0;
    else if (arm) done_q <= 1'b0;
    else          done_q <= lock_tgl;
  end

  assign win  = open_q;
  assign done = done_q;

  AST_OPEN_NEEDS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_q) |-> $past(ring_fall));  // R2
  AST_RISE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_rise && !arm) |=> $stable(open_q));  // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);  // R5
  AST_DONE_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!open_q && $past(open_q, 2)));  // R5
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !arm) |=> ($stable(open_q) && lock_q));  // R6
  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (!open_q && !lock_q && !done_q));  // R7 R8
endmodule

// File: tb/sim_ring_gate.sv
module sim_ring_gate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 1'b0;
  logic ring_in = 1'b1;
  logic win, done;

  int checks = 0;
  int failures = 0;
  int win_cnt = 0;
  int done_cnt = 0;

  localparam int NV = 6;
  localparam int VEC_LOW [NV] = '{2, 5, 1, 12, 3, 40};
  localparam int VEC_HIGH[NV] = '{2, 3, 10, 1, 7, 25};

  always #10 clk = ~clk;

  ring_gate u0 (
    .clk(clk), .rst_n(rst_n), .arm(arm), .ring_in(ring_in),
    .win(win), .done(done)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // From a point just after a rising edge: sample at the negedge, tally,
  // and move to just after the next rising edge.
  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (win)  win_cnt++;
      if (done) done_cnt++;
      @(posedge clk); #1;
    end
  endtask

  task automatic arm_pulse();
    arm = 1'b1;
    cyc(1);
    arm = 1'b0;
  endtask

  task automatic clear_tally();
    win_cnt = 0;
    done_cnt = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    chk(win, 0, "R1 win during reset");
    chk(done, 0, "R1 done during reset");
    @(posedge clk); #1;
    rst_n = 1'b1;
    cyc(5);
    chk(win, 0, "R1 win after reset");

    // R1/R2: first period measured without any arm, exact opening latency.
    ring_in = 1'b0;
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk(win, 0, "R2 win still closed after k+2");
    @(negedge clk);
    chk(win, 1, "R2 win open after k+3 (R1 no arm needed)");
    @(posedge clk); #1;
    cyc(4);
    // R3: a rising edge in the window does not close it.
    ring_in = 1'b1;
    cyc(8);
    @(negedge clk);
    chk(win, 1, "R3 rise keeps window open");
    @(posedge clk); #1;
    // R4/R5: second fall closes, done pulse one clock later.
    ring_in = 1'b0;
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk(win, 1, "R4 win still open after m+2");
    @(negedge clk);
    chk(win, 0, "R4 win closed after m+3");
    chk(done, 0, "R5 done not yet at close");
    @(negedge clk);
    chk(done, 1, "R5 done one clock after close");
    @(negedge clk);
    chk(done, 0, "R5 done lasts one clock");
    @(posedge clk); #1;

    // Table: per vector, period = low + high clocks; a third fall must be ignored (R6).
    for (int v = 0; v < NV; v++) begin
      ring_in = 1'b1;
      arm_pulse();
      cyc(5);
      clear_tally();
      ring_in = 1'b0;
      cyc(VEC_LOW[v]);
      ring_in = 1'b1;
      cyc(VEC_HIGH[v]);
      ring_in = 1'b0;
      cyc(10);
      ring_in = 1'b1;
      cyc(3);
      ring_in = 1'b0;
      cyc(10);
      chk(win_cnt, VEC_LOW[v] + VEC_HIGH[v], $sformatf("R4 window width vec %0d", v));
      chk(done_cnt, 1, $sformatf("R5 done count vec %0d", v));
      chk(win, 0, $sformatf("R6 locked after extra fall vec %0d", v));
    end

    // R6: repeated edges after lock, no window and no done.
    clear_tally();
    for (int i = 0; i < 4; i++) begin
      ring_in = 1'b1; cyc(3);
      ring_in = 1'b0; cyc(3);
    end
    cyc(5);
    chk(win_cnt, 0, "R6 no window after lock");
    chk(done_cnt, 0, "R6 no done after lock");

    // R3: rising edge alone on an armed block opens nothing.
    arm_pulse();
    cyc(3);
    clear_tally();
    ring_in = 1'b1;
    cyc(8);
    chk(win_cnt, 0, "R3 rise alone does not open");

    // R7: after arm, the next fall opens a new window.
    ring_in = 1'b0;
    cyc(4);
    @(negedge clk);
    chk(win, 1, "R7 rearmed window opens");
    @(posedge clk); #1;

    // R8: arm while open closes it with no done.
    cyc(5);
    clear_tally();
    arm_pulse();
    chk(win_cnt, 1, "R8 window still open before arm edge");
    clear_tally();
    cyc(10);
    chk(win_cnt, 0, "R8 window closed by arm");
    chk(done_cnt, 0, "R8 no done after arm abort");

    // R9: single fall, no second one.
    ring_in = 1'b1;
    cyc(4);
    ring_in = 1'b0;
    cyc(4);
    clear_tally();
    cyc(2000);
    chk(win_cnt, 2000, "R9 window stays open");
    chk(done_cnt, 0, "R9 no done without second fall");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule